// File: doc/BRIEF.md
# Predicated Eight-Lane Vector Execute Stage

This block is the execute stage of a vector core. One decoded operation is applied to every lane in the same cycle. Each lane computes a multiply-add on integers and holds its own result register. An if/else region in the instruction stream is carried out by switching lanes on and off with a lane mask, not by branching.

An opening operation compares every lane's first operand with zero and narrows the mask to the lanes that take the "then" side. A switch operation hands the remaining lanes of the enclosing region the "else" side. A closing operation restores the mask that held before the region opened. Regions may nest. A lane that is switched off keeps its previous result and raises no write enable.

When a side of a region holds no lanes at all, the unit raises a skip hint so that the sequencer can step past that side. Any operation still issued there executes nothing and is left out of the utilization counters. Two running counters let a user measure efficiency: one counts lane-cycles that did useful work, the other counts all lane-cycles spent.

Top module: `simd_mask_unit`

## Requirements
- R1: With every lane enabled, an issued operation (op_valid=1, op_kind=0 execute) makes every lane write the low DW bits of a*b+c. The result and res_we=all ones appear after the next rising clock edge.
- R2: An opening operation (op_kind=1) pushes the current mask. It then sets the mask to the current mask ANDed with a per-lane predicate, which is 1 when that lane's op_a slice, taken as signed, is greater than zero. Lane i uses bits [i*DW +: DW] and mask bit i.
- R3: A lane whose mask bit is 0 during an execute raises no write-enable bit and keeps its previous result unchanged.
- R4: A switch operation (op_kind=2) inside a region sets the mask to the parent mask ANDed with the inverse of the current mask.
- R5: A closing operation (op_kind=3) restores the mask that was in force before the matching opening operation. At nesting depth 0 the mask is all ones, so execution continues at full width.
- R6: Nesting reaches a depth of DEPTH. An opening operation at full depth is ignored. Closing and switch operations at depth 0 are ignored.
- R7: skip_hint equals 1 exactly when the mask is all zero. An execute issued under an all-zero mask writes nothing and leaves both counters unchanged.
- R8: Each execute issued under a non-zero mask adds LANES to total_cnt and adds the number of enabled lanes to active_cnt. With a single enabled lane, this gives 1/8 utilization.
- R9: A synchronous active-high reset clears results, res_we and both counters to 0, sets the mask to all ones and sets the depth to 0. An operation with op_valid=0 changes nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 execute, 1 open region, 2 switch side, 3 close region |
| op_a | input | LANES*DW | Multiplicand per lane; also the predicate source |
| op_b | input | LANES*DW | Multiplier per lane |
| op_c | input | LANES*DW | Addend per lane |
| res_data | output | LANES*DW | Registered lane results |
| res_we | output | LANES | Lanes written by the last execute |
| lane_mask | output | LANES | Current lane mask |
| skip_hint | output | 1 | Mask is empty; the current side may be skipped |
| active_cnt | output | CW | Useful lane-cycles |
| total_cnt | output | CW | Spent lane-cycles |

## Verification
The bench builds the block with its defaults: LANES=8, DW=16, DEPTH=4 and CW=32. At these values a single enabled lane gives the 1/8 worst case, and four nested regions reach the full depth of the mask stack, so the ignored fifth opening operation can be exercised. Sixteen-bit lanes allow operands whose product overflows and wraps, as well as negative and zero predicate inputs. A region whose lanes all agree drives the mask to zero, which exposes both the skip hint and the counter hold.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_OPEN  = 2'd1,
    OP_SWAP  = 2'd2,
    OP_CLOSE = 2'd3
  } op_e;
endpackage

// File: rtl/simd_mask_lane.sv
module simd_mask_lane #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          en,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] y,
  output logic          we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      y  <= '0;
      we <= 1'b0;
    end else begin
      we <= fire & en;
      if (fire && en) y <= a * b + c;
    end
  end

  // R3: a disabled lane keeps its result
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && !en) |=> $stable(y));
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
  import simd_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int DPW = $clog2(DEPTH + 1),
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [1:0]       kind,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] mask,
  output logic [DPW-1:0]   depth
);
  logic [LANES-1:0] stk [DEPTH];
  logic [IW-1:0]    push_idx, top_idx;
  op_e              k;

  assign k        = op_e'(kind);
  assign push_idx = IW'(depth);
  assign top_idx  = IW'(depth - DPW'(1));

  always_ff @(posedge clk) begin
    if (issue && k == OP_OPEN && depth < DPW'(DEPTH)) stk[push_idx] <= mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '1;
      depth <= '0;
    end else if (issue) begin
      case (k)
        OP_OPEN: if (depth < DPW'(DEPTH)) begin
          mask  <= mask & pred;
          depth <= depth + DPW'(1);
        end
        OP_SWAP: if (depth != '0) mask <= stk[top_idx] & ~mask;
        OP_CLOSE: if (depth != '0) begin
          mask  <= stk[top_idx];
          depth <= depth - DPW'(1);
        end
        default: ;
      endcase
    end
  end

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
    depth <= DPW'(DEPTH));
  assert_swap_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
    (issue && k == OP_SWAP && depth != '0) |=> ((mask & $past(mask)) == '0));
  assert_full_at_root_R5: assert property (@(posedge clk) disable iff (rst)
    (depth == '0) |-> (mask == '1));
endmodule

// File: rtl/simd_mask_util.sv
module simd_mask_util #(
  parameter int LANES = 8,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [LANES-1:0] mask,
  output logic [CW-1:0]    active_cnt,
  output logic [CW-1:0]    total_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_cnt <= '0;
      total_cnt  <= '0;
    end else if (fire) begin
      active_cnt <= active_cnt + CW'($countones(mask));
      total_cnt  <= total_cnt + CW'(LANES);
    end
  end

  assert_cnt_order_R8: assert property (@(posedge clk) disable iff (rst)
    active_cnt <= total_cnt);
  assert_total_step_R8: assert property (@(posedge clk) disable iff (rst)
    (total_cnt == $past(total_cnt)) || (total_cnt == $past(total_cnt) + CW'(LANES)));
endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit
  import simd_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 32,
  localparam int VW   = LANES * DW,
  localparam int DPW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [VW-1:0]    op_a,
  input  logic [VW-1:0]    op_b,
  input  logic [VW-1:0]    op_c,
  output logic [VW-1:0]    res_data,
  output logic [LANES-1:0] res_we,
  output logic [LANES-1:0] lane_mask,
  output logic             skip_hint,
  output logic [CW-1:0]    active_cnt,
  output logic [CW-1:0]    total_cnt
);
  logic [LANES-1:0] pred;
  logic [DPW-1:0]   depth;
  logic             fire;

  assign fire      = op_valid && (op_e'(op_kind) == OP_EXEC) && (lane_mask != '0);
  assign skip_hint = (lane_mask == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pred[i] = $signed(op_a[i*DW +: DW]) > 0;
    simd_mask_lane #(.DW(DW)) u_lane (
      .clk (clk),
      .rst (rst),
      .fire(fire),
      .en  (lane_mask[i]),
      .a   (op_a[i*DW +: DW]),
      .b   (op_b[i*DW +: DW]),
      .c   (op_c[i*DW +: DW]),
      .y   (res_data[i*DW +: DW]),
      .we  (res_we[i])
    );
  end

  simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk  (clk),
    .rst  (rst),
    .issue(op_valid),
    .kind (op_kind),
    .pred (pred),
    .mask (lane_mask),
    .depth(depth)
  );

  simd_mask_util #(.LANES(LANES), .CW(CW)) u_util (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .mask      (lane_mask),
    .active_cnt(active_cnt),
    .total_cnt (total_cnt)
  );

  assert_we_in_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (res_we & ~$past(lane_mask)) == '0);
  assert_empty_no_we_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(lane_mask) == '0) |-> (res_we == '0 && $stable(total_cnt)));
  assert_idle_no_we_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(op_valid) |-> (res_we == '0));
endmodule

// File: tb/sim_simd_mask_unit.sv
module sim_simd_mask_unit;
  localparam int L = 8;
  localparam int DW = 16;
  localparam int D = 4;

  logic clk = 0, rst = 1;
  logic op_valid = 0;
  logic [1:0] op_kind = 0;
  logic [L*DW-1:0] op_a, op_b, op_c, res_data;
  logic [L-1:0] res_we, lane_mask;
  logic skip_hint;
  logic [31:0] active_cnt, total_cnt;

  logic [DW-1:0] va [L], vb [L], vc [L];
  logic [DW-1:0] ey [L];
  logic [L-1:0]  em, ewe;
  logic [L-1:0]  estk [D];
  int edep, eact, etot;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < L; i++) begin
      op_a[i*DW +: DW] = va[i];
      op_b[i*DW +: DW] = vb[i];
      op_c[i*DW +: DW] = vc[i];
    end
  end

  simd_mask_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .res_data(res_data),
    .res_we(res_we), .lane_mask(lane_mask), .skip_hint(skip_hint),
    .active_cnt(active_cnt), .total_cnt(total_cnt)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "res_we", res_we, ewe);
    chk(tag, "mask", lane_mask, em);
    chk(tag, "skip_hint", skip_hint, em == 0);
    chk(tag, "active_cnt", active_cnt, eact);
    chk(tag, "total_cnt", total_cnt, etot);
    for (int i = 0; i < L; i++) chk(tag, "lane data", res_data[i*DW +: DW], ey[i]);
  endtask

  task automatic step(input logic v, input logic [1:0] k, input string tag);
    logic [L-1:0] p;
    op_valid = v;
    op_kind  = k;
    ewe = '0;
    for (int i = 0; i < L; i++) p[i] = $signed(va[i]) > 0;
    if (v) begin
      case (k)
        2'd0: if (em != 0) begin
          for (int i = 0; i < L; i++)
            if (em[i]) begin
              ey[i] = va[i] * vb[i] + vc[i];
              eact++;
            end
          ewe = em;
          etot += L;
        end
        2'd1: if (edep < D) begin estk[edep] = em; edep++; em = em & p; end
        2'd2: if (edep > 0) em = estk[edep-1] & ~em;
        default: if (edep > 0) begin edep--; em = estk[edep]; end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic load(input int seed, input logic [L-1:0] pos);
    for (int i = 0; i < L; i++) begin
      va[i] = pos[i] ? DW'(seed + 3*i + 1) : ((i % 2) ? DW'(0) : DW'(-(i + seed)));
      vb[i] = DW'(seed * 7 + i * 13 + 2);
      vc[i] = DW'(seed * 5 + i);
    end
  endtask

  initial begin
    for (int i = 0; i < L; i++) ey[i] = '0;
    em = '1; ewe = '0; edep = 0; eact = 0; etot = 0;
    load(1, '1);
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R9");
    load(2, '1);          step(1, 0, "R1");
    load(300, '1);        step(1, 0, "R1");   // product wraps
    load(3, 8'b00001011); step(1, 1, "R2");
    load(4, '1);          step(1, 0, "R3");
    step(1, 2, "R4");
    load(5, '1);          step(1, 0, "R3");
    load(6, 8'b00000100); step(1, 1, "R2");
    load(7, '1);          step(1, 0, "R8");   // one lane of eight
    step(1, 3, "R5");
    load(8, '1);          step(1, 0, "R5");
    step(1, 3, "R5");
    load(9, '1);          step(1, 0, "R5");
    load(10, '1);         step(1, 1, "R7");
    step(1, 2, "R7");
    load(11, '1);         step(1, 0, "R7");
    step(1, 3, "R7");
    load(12, 8'b00000000); step(1, 1, "R7");
    step(1, 0, "R7");
    step(1, 3, "R7");
    for (int d = 0; d < D; d++) begin
      load(20 + d, ~(8'b1 << d));
      step(1, 1, "R6");
    end
    load(30, 8'b00000000); step(1, 1, "R6");  // ignored at full depth
    load(31, '1);         step(1, 0, "R6");
    for (int d = 0; d < D; d++) step(1, 3, "R6");
    step(1, 3, "R6");
    step(1, 2, "R6");
    load(32, '1);         step(1, 0, "R6");
    load(33, '1);         step(0, 0, "R9");
    step(0, 1, "R9");
    load(34, 8'b10000001); step(1, 1, "R2");
    load(35, '1);         step(1, 0, "R8");
    step(1, 2, "R4");
    load(36, '1);         step(1, 0, "R8");
    step(1, 3, "R5");
    load(37, '1);         step(1, 0, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule